// File: doc/BRIEF.md
# Clock Register Bus with Hold Handshake

This block is the host-facing register port of a calendar clock. A host reaches thirteen 4-bit time and date digits and three 4-bit control registers through a 4-bit address, a 4-bit write path, a 4-bit read path with an output-enable, separate write and read strobes, and an active-high chip-select. The digit registers live here. The next-second values come from an external counter, and the one-second request comes from an external period generator.

The block applies each one-second increment over a short busy window. To read or set the digits coherently, the host sets a hold bit and then polls a busy bit. The digits are accessible only while busy reads 0. An increment that arrives while hold is set is deferred, and at most one such increment is kept. That increment runs as soon as hold is cleared, either by a register write or by dropping chip-select. Chip-select going low also releases the sub-second reset bit of the third control register.

Top module: `rtc_nibble_bus`

## Requirements
- R1: Addresses 0x0 to 0xC select the digits in this order: seconds units, seconds tens, minutes units, minutes tens, hours units, hours tens, day units, day tens, month units, month tens, year units, year tens, weekday. A digit written while busy reads 0 reads back unchanged.
- R2: At address 0xD, bit 3 is the 30-second adjust bit, bit 2 is the interrupt flag, bit 1 is busy and bit 0 is hold. Bits 3, 2 and 0 read back as last written.
- R3: Addresses 0xE and 0xF read back all four bits as last written. On the `cfg_e` and `cfg_f` outputs, bit 0 of 0xF is the sub-second reset bit.
- R4: Busy (bit 1 of 0xD) reads 1 whenever hold is 0.
- R5: While hold is 1, busy reads 1 during an increment window and 0 otherwise.
- R6: A `sec_tick` pulse seen with hold 0 and no increment in progress opens an increment window of INC_CYC cycles. At the last edge of that window, all digits load `nxt_digits`.
- R7: A `sec_tick` seen while hold is 1 and no increment is in progress is deferred. Any number of further ticks during the same hold still leave only one deferred increment.
- R8: When hold reads 0 with an increment deferred, the window starts at the next edge. The digits load exactly once, INC_CYC edges later.
- R9: A clock edge with `cs` low clears hold and the sub-second reset bit. The other control bits are kept.
- R10: A write to a digit address while busy reads 1 has no effect.
- R11: Writes to 0xE, 0xF and 0xD take effect whatever the busy state.
- R12: A write to bit 1 of 0xD has no effect on the busy bit.
- R13: `rdata_oe` is high exactly when `cs` and `rd_en` are both high. `rdata` shows the addressed register in the same cycle.
- R14: A `sec_tick` that arrives during an increment window is dropped and is not deferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip-select, active high |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 4 | Register address |
| wdata | input | 4 | Write data |
| rdata | output | 4 | Read data of the addressed register |
| rdata_oe | output | 1 | Drive enable for the read data |
| sec_tick | input | 1 | One-second increment request, one cycle wide |
| nxt_digits | input | 52 | Next-second digit values from the external counter, digit i in bits 4i+3..4i |
| digits | output | 52 | Current digit values, same packing |
| adj30 | output | 1 | 30-second adjust bit |
| irq_flag | output | 1 | Interrupt flag bit |
| cfg_e | output | 4 | Contents of register 0xE |
| cfg_f | output | 4 | Contents of register 0xF |

## Verification
Register writes, hold changes and the chip-select clear all show up one edge after the strobe. Reads are combinational and are sampled 1 ns after the strobe is driven at a falling edge. An accepted tick raises busy at the next edge and changes the digits INC_CYC edges after the tick. A deferred tick changes the digits INC_CYC + 1 edges after the edge where hold is seen cleared. The bench steps a behavioural model on every rising edge from the same inputs, then compares the digits and control outputs 1 ns later. The directed sequences check the same timings with literal values.

// File: rtl/rtc_bus_pkg.sv
`timescale 1ns/1ps
package rtc_bus_pkg;
  localparam int AW = 4;
  localparam int DW = 4;
  localparam logic [AW-1:0] ADR_STAT = 4'hD;
  localparam logic [AW-1:0] ADR_MODE = 4'hE;
  localparam logic [AW-1:0] ADR_CONF = 4'hF;
  localparam int BIT_ADJ  = 3;
  localparam int BIT_IRQ  = 2;
  localparam int BIT_BUSY = 1;
  localparam int BIT_HOLD = 0;
  localparam int BIT_SRST = 0;

  function automatic logic is_digit(input logic [AW-1:0] a, input int ndig);
    return int'(a) < ndig;
  endfunction

  function automatic logic busy_flag(input logic hold, input logic inc_busy);
    return !hold || inc_busy;
  endfunction
endpackage

// File: rtl/rtc_hold_seq.sv
`timescale 1ns/1ps
module rtc_hold_seq #(
  parameter int INC_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic tick,
  input  logic hold_wr,
  input  logic hold_val,
  output logic hold_q,
  output logic pend_q,
  output logic inc_busy,
  output logic commit,
  output logic busy_rd
);
  import rtc_bus_pkg::*;
  localparam int CW = (INC_CYC < 2) ? 1 : $clog2(INC_CYC);

  logic [CW-1:0] cnt_q;
  logic start;
  logic defer;

  assign commit  = inc_busy && (cnt_q == '0);
  assign start   = (tick || pend_q) && !hold_q && !inc_busy;
  assign defer   = tick && hold_q && !inc_busy;
  assign busy_rd = busy_flag(hold_q, inc_busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= 1'b0;
      pend_q   <= 1'b0;
      inc_busy <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (!cs)          hold_q <= 1'b0;
      else if (hold_wr) hold_q <= hold_val;

      if (start)      pend_q <= 1'b0;
      else if (defer) pend_q <= 1'b1;

      if (start) begin
        inc_busy <= 1'b1;
        cnt_q    <= CW'(INC_CYC - 1);
      end else if (commit) begin
        inc_busy <= 1'b0;
      end else if (inc_busy) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R7
  single_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && hold_q && cs && !hold_wr) |=> pend_q);
  // R8
  release_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !hold_q && !inc_busy) |=> (inc_busy && !pend_q));
  // R6
  window_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !inc_busy);
  // R14
  tick_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && inc_busy && !commit) |=> (inc_busy && $stable(pend_q)));
endmodule

// File: rtl/rtc_digit_file.sv
`timescale 1ns/1ps
module rtc_digit_file #(
  parameter int NDIG = 13,
  parameter int DW   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [NDIG*DW-1:0]   nxt,
  input  logic                 wr,
  input  logic [3:0]           wr_idx,
  input  logic [DW-1:0]        wdata,
  output logic [NDIG*DW-1:0]   flat
);
  logic [DW-1:0] dig_q [NDIG];

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          dig_q[i] <= '0;
      else if (load)                       dig_q[i] <= nxt[i*DW +: DW];
      else if (wr && (wr_idx == 4'(i)))    dig_q[i] <= wdata;
    end
    assign flat[i*DW +: DW] = dig_q[i];
  end

  // R10
  no_load_write_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && wr));
endmodule

// File: rtl/rtc_ctrl_regs.sv
`timescale 1ns/1ps
module rtc_ctrl_regs #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          wr_stat,
  input  logic          wr_mode,
  input  logic          wr_conf,
  input  logic [DW-1:0] wdata,
  output logic          adj_q,
  output logic          irq_q,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] conf_q
);
  import rtc_bus_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adj_q  <= 1'b0;
      irq_q  <= 1'b0;
      mode_q <= '0;
      conf_q <= '0;
    end else begin
      if (wr_stat) begin
        adj_q <= wdata[BIT_ADJ];
        irq_q <= wdata[BIT_IRQ];
      end
      if (wr_mode) mode_q <= wdata;
      if (wr_conf) conf_q <= wdata;
      if (!cs)     conf_q[BIT_SRST] <= 1'b0;
    end
  end

  // R3
  conf_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_conf && cs) |=> (conf_q == $past(wdata)));
endmodule

// File: rtl/rtc_nibble_bus.sv
`timescale 1ns/1ps
module rtc_nibble_bus #(
  parameter int NDIG    = 13,
  parameter int INC_CYC = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cs,
  input  logic                                   rd_en,
  input  logic                                   wr_en,
  input  logic [rtc_bus_pkg::AW-1:0]             addr,
  input  logic [rtc_bus_pkg::DW-1:0]             wdata,
  output logic [rtc_bus_pkg::DW-1:0]             rdata,
  output logic                                   rdata_oe,
  input  logic                                   sec_tick,
  input  logic [NDIG*rtc_bus_pkg::DW-1:0]        nxt_digits,
  output logic [NDIG*rtc_bus_pkg::DW-1:0]        digits,
  output logic                                   adj30,
  output logic                                   irq_flag,
  output logic [rtc_bus_pkg::DW-1:0]             cfg_e,
  output logic [rtc_bus_pkg::DW-1:0]             cfg_f
);
  import rtc_bus_pkg::*;

  logic bus_wr;
  logic wr_digit;
  logic wr_stat, wr_mode, wr_conf;
  logic hold_q, pend_q, inc_busy, commit, busy_rd;

  assign bus_wr   = cs && wr_en;
  assign wr_digit = bus_wr && is_digit(addr, NDIG) && !busy_rd;
  assign wr_stat  = bus_wr && (addr == ADR_STAT);
  assign wr_mode  = bus_wr && (addr == ADR_MODE);
  assign wr_conf  = bus_wr && (addr == ADR_CONF);

  rtc_hold_seq #(.INC_CYC(INC_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .cs(cs), .tick(sec_tick),
    .hold_wr(wr_stat), .hold_val(wdata[BIT_HOLD]),
    .hold_q(hold_q), .pend_q(pend_q), .inc_busy(inc_busy),
    .commit(commit), .busy_rd(busy_rd)
  );

  rtc_digit_file #(.NDIG(NDIG), .DW(DW)) u_dig (
    .clk(clk), .rst_n(rst_n), .load(commit), .nxt(nxt_digits),
    .wr(wr_digit), .wr_idx(addr), .wdata(wdata), .flat(digits)
  );

  rtc_ctrl_regs #(.DW(DW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cs(cs),
    .wr_stat(wr_stat), .wr_mode(wr_mode), .wr_conf(wr_conf), .wdata(wdata),
    .adj_q(adj30), .irq_q(irq_flag), .mode_q(cfg_e), .conf_q(cfg_f)
  );

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NDIG; i++)
      if (addr == AW'(i)) rdata = digits[i*DW +: DW];
    case (addr)
      ADR_STAT: begin
        rdata[BIT_ADJ]  = adj30;
        rdata[BIT_IRQ]  = irq_flag;
        rdata[BIT_BUSY] = busy_rd;
        rdata[BIT_HOLD] = hold_q;
      end
      ADR_MODE: rdata = cfg_e;
      ADR_CONF: rdata = cfg_f;
      default: ;
    endcase
  end

  assign rdata_oe = cs && rd_en;

  // R9
  cs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> (!hold_q && !cfg_f[BIT_SRST]));
  // R10
  busy_write_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && is_digit(addr, NDIG) && busy_rd && !commit) |=> $stable(digits));
  // R12
  hold_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && cs) |=> (hold_q == $past(wdata[BIT_HOLD])));
  // R6
  window_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inc_busy) |-> ($past(sec_tick) || $past(pend_q)));
endmodule

// File: tb/tb_rtc_nibble_bus.sv
`timescale 1ns/1ps
module tb_rtc_nibble_bus;
  localparam int NDIG = 13;
  localparam int INC  = 3;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b1, rd_en = 1'b0, wr_en = 1'b0, sec_tick = 1'b0;
  logic [3:0] addr = '0, wdata = '0;
  logic [3:0] rdata;
  logic rdata_oe, adj30, irq_flag;
  logic [3:0] cfg_e, cfg_f;
  logic [NDIG*4-1:0] nxt_digits, digits;

  int n_chk = 0, n_fail = 0;

  rtc_nibble_bus #(.NDIG(NDIG), .INC_CYC(INC)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .sec_tick(sec_tick), .nxt_digits(nxt_digits), .digits(digits),
    .adj30(adj30), .irq_flag(irq_flag), .cfg_e(cfg_e), .cfg_f(cfg_f)
  );

  always #2.5 clk = ~clk;

  // external counter stand-in: every digit steps by one, modulo 16
  always_comb
    for (int i = 0; i < NDIG; i++) nxt_digits[i*4 +: 4] = digits[i*4 +: 4] + 4'd1;

  // behavioural reference
  bit [3:0] m_dig [NDIG];
  bit m_hold, m_pend, m_adj, m_irq;
  bit [3:0] m_e, m_f;
  int m_cnt;

  function automatic bit m_busy();
    return !m_hold || (m_cnt > 0);
  endfunction

  function automatic bit [3:0] m_read(input bit [3:0] a);
    if (a < 13) return m_dig[a];
    if (a == 13) return {m_adj, m_irq, m_busy(), m_hold};
    if (a == 14) return m_e;
    return m_f;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin : model
    bit was_busy, commit, start;
    int old_cnt;
    if (!rst_n) begin
      for (int i = 0; i < NDIG; i++) m_dig[i] = '0;
      m_hold = 0; m_pend = 0; m_adj = 0; m_irq = 0; m_e = '0; m_f = '0; m_cnt = 0;
    end else begin
      was_busy = m_busy();
      old_cnt  = m_cnt;
      commit   = (m_cnt == 1);
      start    = (sec_tick || m_pend) && !m_hold && (m_cnt == 0);
      if (commit) for (int i = 0; i < NDIG; i++) m_dig[i] = m_dig[i] + 4'd1;
      if (cs && wr_en && addr < 13 && !was_busy) m_dig[addr] = wdata;
      if (m_cnt > 0) m_cnt--;
      if (start) m_cnt = INC;
      if (start) m_pend = 0;
      else if (sec_tick && m_hold && old_cnt == 0) m_pend = 1;
      if (cs && wr_en) begin
        if (addr == 13) begin m_adj = wdata[3]; m_irq = wdata[2]; m_hold = wdata[0]; end
        if (addr == 14) m_e = wdata;
        if (addr == 15) m_f = wdata;
      end
      if (!cs) begin m_hold = 0; m_f[0] = 0; end
    end
    #1;
    for (int i = 0; i < NDIG; i++)
      chk(digits[i*4 +: 4] == m_dig[i], "R6 digit", digits[i*4 +: 4], m_dig[i]);
    chk(cfg_e == m_e, "R3 cfg_e", cfg_e, m_e);
    chk(cfg_f == m_f, "R9 cfg_f", cfg_f, m_f);
    chk({adj30, irq_flag} == {m_adj, m_irq}, "R2 adj/irq", {adj30, irq_flag}, {m_adj, m_irq});
  end

  task automatic bus_wr(input bit [3:0] a, input bit [3:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input bit [3:0] a, input string tag);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1;
    chk(rdata_oe == 1'b1, "R13 oe", rdata_oe, 1);
    if (!(a < 13 && m_busy()))
      chk(rdata == m_read(a), tag, rdata, m_read(a));
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rd_lit(input bit [3:0] a, input bit [3:0] exp, input string tag);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1; chk(rdata == exp, tag, rdata, exp);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : wdog
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    // R4 R2: busy reads 1 with hold 0 after reset
    rd_lit(4'hD, 4'b0010, "R4 status after reset");
    rd_lit(4'h0, 4'h0, "R1 digit reset");
    // R11 R3: control writes while busy
    bus_wr(4'hE, 4'b1011);
    bus_wr(4'hF, 4'b0111);
    rd_lit(4'hE, 4'b1011, "R11 mode readback");
    rd_lit(4'hF, 4'b0111, "R3 conf readback");
    // R10: digit write with hold 0 ignored
    bus_wr(4'h3, 4'h9);
    idle(1);
    chk(digits[15:12] == 4'h0, "R10 write during busy", digits[15:12], 0);
    // R12 R5: hold set, busy bit written 1 ignored
    bus_wr(4'hD, 4'b1011);
    rd_lit(4'hD, 4'b1001, "R12 status with hold");
    // R1: fill and read back all digits
    for (int i = 0; i < NDIG; i++) bus_wr(4'(i), 4'(i + 2));
    for (int i = 0; i < NDIG; i++) bus_rd(4'(i), "R1 digit readback");
    rd_lit(4'hC, 4'hE, "R1 weekday slot");
    // R7: ticks under hold are deferred, only one kept
    pulse_tick(); idle(INC + 2);
    chk(digits[3:0] == 4'h2, "R7 deferred no change", digits[3:0], 2);
    rd_lit(4'hD, 4'b1001, "R5 idle under hold");
    pulse_tick(); pulse_tick(); pulse_tick(); idle(2);
    // R8: release hold, exactly one increment
    bus_wr(4'hD, 4'b1000);
    rd_lit(4'hD, 4'b1010, "R8 busy after release");
    idle(INC + 3);
    chk(digits[3:0] == 4'h3, "R8 single increment", digits[3:0], 3);
    chk(digits[51:48] == 4'hF, "R8 weekday increment", digits[51:48], 15);
    // R6 R14: tick with hold 0, second tick inside window dropped
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    idle(INC + 3);
    chk(digits[3:0] == 4'h4, "R14 one increment", digits[3:0], 4);
    // R5: hold set during window keeps busy up
    pulse_tick();
    bus_wr(4'hD, 4'b0001);
    bus_rd(4'hD, "R5 busy in window");
    idle(INC + 2);
    rd_lit(4'hD, 4'b0001, "R5 window over under hold");
    chk(digits[3:0] == 4'h5, "R6 increment with hold late", digits[3:0], 5);
    // R9: cs low clears hold and sub-second reset
    @(negedge clk); cs = 1'b0; rd_en = 1'b1;
    #1; chk(rdata_oe == 1'b0, "R13 oe with cs low", rdata_oe, 0);
    @(negedge clk); cs = 1'b1; rd_en = 1'b0;
    rd_lit(4'hF, 4'b0110, "R9 conf after cs low");
    rd_lit(4'hD, 4'b0010, "R9 status after cs low");
    rd_lit(4'hE, 4'b1011, "R9 mode kept");
    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule